// File: doc/BRIEF.md
# Multi-Client Shared Set-Associative Cache

This block is a last-level cache shared by several clients. Each client has its own request port and its own address space. The cache builds its internal address by joining the client ID above the client address. The low bits of the client address choose the set. The ID and the remaining address bits form the tag, so lines that belong to different clients never alias. Capacity is not split between clients: any client may hold any way of any set, and the least-recently-used policy decides who keeps space.

On a miss the cache evicts a victim way. If that victim is dirty, the line goes to the spill port of the client named in its tag. The cache then asks the requesting client for the line through that client's fill port. Responses, fill requests and spills each raise only the valid bit of the client concerned. Only one request is in flight at a time: while a miss is outstanding, no new request is granted.

The controller has six states:
- IDLE grants the lowest-numbered requesting client and moves to LOOKUP.
- LOOKUP moves to RESPOND on a hit. On a miss with a dirty victim it moves to SPILL; otherwise it moves to FILL_REQ.
- SPILL always moves to FILL_REQ.
- FILL_REQ always moves to FILL_WAIT.
- FILL_WAIT moves to RESPOND when the owning client returns the line.
- RESPOND always returns to IDLE.

Top module: `mcc_shared_cache`

## Requirements
- R1: After reset, with no requests present, req_ready, rsp_valid, fill_req_valid and spill_valid are all zero, and every line is invalid.
- R2: A read by client c of address a returns the last value written by client c to address a, or that client's backing value if it never wrote there. Writes by other clients to the same address have no effect on it.
- R3: A read or write that hits raises no fill request. Its response appears two cycles after the acceptance cycle, and never in the cycle right after acceptance.
- R4: A miss raises exactly one fill_req_valid bit, the requester's, for one cycle, with fill_addr equal to the requested client address.
- R5: A dirty victim is written out on spill_valid of the client held in its tag, one cycle before the fill request. spill_addr is the victim's client address and spill_data is its contents. A clean victim causes no spill.
- R6: A miss fills an invalid way of the set before any valid line is evicted. A single client can therefore occupy all 4 ways of a set.
- R7: When all ways of a set are valid, the victim is the least recently used way. A hit or a fill makes that way the most recent.
- R8: From a fill request until the matching response, req_ready stays zero.
- R9: In IDLE, req_ready is one-hot on the lowest-numbered client whose req_valid is high, and zero when no client requests.
- R10: rsp_valid has at most one bit set, and that bit belongs to the client whose request is completing. Write requests are acknowledged with rsp_data equal to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N | Per-client request valid |
| req_ready | output | N | Per-client grant; the request transfers when both are high |
| req_we | input | N | Per-client write enable (1 = write) |
| req_addr | input | N*AW | Per-client address, client c at bits [c*AW +: AW] |
| req_wdata | input | N*DW | Per-client write data, client c at bits [c*DW +: DW] |
| rsp_valid | output | N | One-hot response valid, routed by client ID |
| rsp_data | output | DW | Read data, or the written value for a write |
| fill_req_valid | output | N | One-hot fill request to the owning client |
| fill_addr | output | AW | Client address of the line to fill |
| fill_rsp_valid | input | N | Per-client fill data valid |
| fill_rsp_data | input | N*DW | Per-client fill data, client c at bits [c*DW +: DW] |
| spill_valid | output | N | One-hot spill strobe to the owner of a dirty victim |
| spill_addr | output | AW | Client address of the spilled line |
| spill_data | output | DW | Contents of the spilled line |

## Verification
Two events can land together in one cycle: a fill returns for the client with the outstanding miss while every other client holds its request high, waiting for a grant. The bench provokes this by launching requests from all four clients on the same edge, each to a missing address, so that three requests wait through a whole miss. It then checks three things: no grant is seen between a fill request and its response, grants come in ascending client order, and each response carries its own client's backing data on that client's rsp_valid bit.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_SPILL,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_RESPOND
    } mcc_state_e;
endpackage

// File: rtl/mcc_arbiter.sv
module mcc_arbiter #(
    parameter int N    = 4,
    parameter int ID_W = 2
) (
    input  logic [N-1:0]    req,
    output logic [N-1:0]    grant,
    output logic [ID_W-1:0] idx,
    output logic            any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = ID_W'(i);
                any = 1'b1;
            end
        end
        grant = any ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/mcc_way_match.sv
module mcc_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            valid,
    input  logic [TAG_W-1:0]           probe,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == probe);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/mcc_lru_age.sv
module mcc_lru_age #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][WAY_W-1:0] age_i,
    input  logic [WAYS-1:0]            valid,
    input  logic [WAY_W-1:0]           touch,
    output logic [WAYS-1:0][WAY_W-1:0] age_o,
    output logic [WAY_W-1:0]           victim
);
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch)
                age_o[w] = '0;
            else if (age_i[w] < age_i[touch])
                age_o[w] = age_i[w] + 1'b1;
            else
                age_o[w] = age_i[w];
        end
    end

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_i[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/mcc_shared_cache.sv
module mcc_shared_cache
    import mcc_pkg::*;
#(
    parameter int N    = 4,
    parameter int AW   = 8,
    parameter int DW   = 16,
    parameter int WAYS = 4,
    parameter int SETS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req_valid,
    output logic [N-1:0]      req_ready,
    input  logic [N-1:0]      req_we,
    input  logic [N*AW-1:0]   req_addr,
    input  logic [N*DW-1:0]   req_wdata,
    output logic [N-1:0]      rsp_valid,
    output logic [DW-1:0]     rsp_data,
    output logic [N-1:0]      fill_req_valid,
    output logic [AW-1:0]     fill_addr,
    input  logic [N-1:0]      fill_rsp_valid,
    input  logic [N*DW-1:0]   fill_rsp_data,
    output logic [N-1:0]      spill_valid,
    output logic [AW-1:0]     spill_addr,
    output logic [DW-1:0]     spill_data
);
    localparam int ID_W  = (N > 1) ? $clog2(N) : 1;
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int TAG_W = ID_W + AW - SET_W;

    mcc_state_e state, nxt;

    logic [ID_W-1:0]  cur_id;
    logic             cur_we;
    logic [AW-1:0]    cur_addr;
    logic [DW-1:0]    cur_wdata;
    logic [DW-1:0]    rsp_q;
    logic [WAY_W-1:0] vic_q;

    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
    logic [SETS-1:0][WAYS-1:0][DW-1:0]    data_q;
    logic [SETS-1:0][WAYS-1:0]            valid_q;
    logic [SETS-1:0][WAYS-1:0]            dirty_q;
    logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;

    logic [N-1:0]     arb_grant;
    logic [ID_W-1:0]  arb_idx;
    logic             arb_any;

    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] probe_tag;
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] vic_sel;
    logic [WAY_W-1:0] touch_way;
    logic [WAYS-1:0][WAY_W-1:0] age_next;
    logic [TAG_W-1:0] vic_tag;
    logic [ID_W-1:0]  vic_owner;
    logic             fill_in;
    logic [DW-1:0]    fill_word;

    assign set_idx   = cur_addr[SET_W-1:0];
    assign probe_tag = {cur_id, cur_addr[AW-1:SET_W]};
    assign touch_way = (state == ST_LOOKUP) ? hit_way : vic_q;
    assign vic_tag   = tag_q[set_idx][vic_q];
    assign vic_owner = vic_tag[TAG_W-1 -: ID_W];
    assign fill_in   = fill_rsp_valid[cur_id];
    assign fill_word = fill_rsp_data[int'(cur_id)*DW +: DW];

    mcc_arbiter #(.N(N), .ID_W(ID_W)) u_arb (
        .req   (req_valid),
        .grant (arb_grant),
        .idx   (arb_idx),
        .any   (arb_any)
    );

    mcc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .tags    (tag_q[set_idx]),
        .valid   (valid_q[set_idx]),
        .probe   (probe_tag),
        .hit     (hit),
        .hit_way (hit_way)
    );

    mcc_lru_age #(.WAYS(WAYS), .WAY_W(WAY_W)) u_lru (
        .age_i  (age_q[set_idx]),
        .valid  (valid_q[set_idx]),
        .touch  (touch_way),
        .age_o  (age_next),
        .victim (vic_sel)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (arb_any) nxt = ST_LOOKUP;
            ST_LOOKUP: begin
                if (hit)
                    nxt = ST_RESPOND;
                else if (valid_q[set_idx][vic_sel] && dirty_q[set_idx][vic_sel])
                    nxt = ST_SPILL;
                else
                    nxt = ST_FILL_REQ;
            end
            ST_SPILL:     nxt = ST_FILL_REQ;
            ST_FILL_REQ:  nxt = ST_FILL_WAIT;
            ST_FILL_WAIT: if (fill_in) nxt = ST_RESPOND;
            ST_RESPOND:   nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_id    <= '0;
            cur_we    <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && arb_any) begin
                cur_id    <= arb_idx;
                cur_we    <= req_we[arb_idx];
                cur_addr  <= req_addr[int'(arb_idx)*AW +: AW];
                cur_wdata <= req_wdata[int'(arb_idx)*DW +: DW];
            end
        end
    end

    // line storage, replacement state and response data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
            vic_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]   <= '0;
                    data_q[s][w]  <= '0;
                    valid_q[s][w] <= 1'b0;
                    dirty_q[s][w] <= 1'b0;
                    age_q[s][w]   <= WAY_W'(w);
                end
            end
        end else begin
            if (state == ST_LOOKUP) begin
                if (hit) begin
                    age_q[set_idx] <= age_next;
                    if (cur_we) begin
                        data_q[set_idx][hit_way]  <= cur_wdata;
                        dirty_q[set_idx][hit_way] <= 1'b1;
                        rsp_q                     <= cur_wdata;
                    end else begin
                        rsp_q <= data_q[set_idx][hit_way];
                    end
                end else begin
                    vic_q <= vic_sel;
                end
            end
            if (state == ST_FILL_WAIT && fill_in) begin
                age_q[set_idx]          <= age_next;
                tag_q[set_idx][vic_q]   <= probe_tag;
                valid_q[set_idx][vic_q] <= 1'b1;
                dirty_q[set_idx][vic_q] <= cur_we;
                data_q[set_idx][vic_q]  <= cur_we ? cur_wdata : fill_word;
                rsp_q                   <= cur_we ? cur_wdata : fill_word;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready      = '0;
        rsp_valid      = '0;
        fill_req_valid = '0;
        spill_valid    = '0;
        rsp_data       = rsp_q;
        fill_addr      = cur_addr;
        spill_addr     = {vic_tag[TAG_W-ID_W-1:0], set_idx};
        spill_data     = data_q[set_idx][vic_q];
        unique case (state)
            ST_IDLE:      req_ready      = arb_grant;
            ST_SPILL:     spill_valid    = N'(1) << vic_owner;
            ST_FILL_REQ:  fill_req_valid = N'(1) << cur_id;
            ST_RESPOND:   rsp_valid      = N'(1) << cur_id;
            default:      ;
        endcase
    end
endmodule

// File: rtl/mcc_shared_cache_chk.sv
module mcc_shared_cache_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_valid,
    input logic [N-1:0] req_ready,
    input logic [N-1:0] rsp_valid,
    input logic [N-1:0] fill_req_valid,
    input logic [N-1:0] spill_valid
);
    logic miss_open;

    always_ff @(posedge clk) begin
        if (!rst_n)
            miss_open <= 1'b0;
        else if (|fill_req_valid)
            miss_open <= 1'b1;
        else if (|rsp_valid)
            miss_open <= 1'b0;
    end

    a_r9_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    a_r9_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) |-> (((req_ready - 1'b1) & req_valid) == '0));

    a_r9_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_ready & ~req_valid) == '0));

    a_r10_rsp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));

    a_r4_fill_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_req_valid));

    a_r5_spill_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (|spill_valid) |=> (|fill_req_valid));

    a_r8_stall_during_miss: assert property (@(posedge clk) disable iff (!rst_n)
        miss_open |-> (req_ready == '0));

    a_r3_no_early_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_valid & req_ready)) |=> (rsp_valid == '0));
endmodule

bind mcc_shared_cache mcc_shared_cache_chk #(.N(N)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .fill_req_valid (fill_req_valid),
    .spill_valid    (spill_valid)
);

// File: tb/sim_mcc_shared_cache.sv
module sim_mcc_shared_cache;
    localparam int N  = 4;
    localparam int AW = 8;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N-1:0]    req_ready;
    logic [N-1:0]    req_we = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic [N*DW-1:0] req_wdata = '0;
    logic [N-1:0]    rsp_valid;
    logic [DW-1:0]   rsp_data;
    logic [N-1:0]    fill_req_valid;
    logic [AW-1:0]   fill_addr;
    logic [N-1:0]    fill_rsp_valid = '0;
    logic [N*DW-1:0] fill_rsp_data = '0;
    logic [N-1:0]    spill_valid;
    logic [AW-1:0]   spill_addr;
    logic [DW-1:0]   spill_data;

    always #5 clk = ~clk;

    mcc_shared_cache #(.N(N), .AW(AW), .DW(DW)) u0 (.*);

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [DW-1:0] bmem [N][256];
    logic [DW-1:0] gm   [N][256];

    int            exp_c_q [$];
    logic [DW-1:0] exp_d_q [$];
    int            exp_t_q [$];
    int            acc_order [$];

    int fill_cnt = 0, spill_cnt = 0, last_lat = 0;
    int last_spill_c = -1, last_spill_cyc = 0, last_fill_cyc = 0;
    logic [AW-1:0] last_spill_addr = '0;
    logic [DW-1:0] last_spill_data = '0;
    bit   busy = 0;
    int   grant_busy = 0;

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // monitor: scoreboard, spill capture, fill counting
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && (req_ready != '0)) grant_busy++;
            if (|spill_valid) begin
                for (int c = 0; c < N; c++) if (spill_valid[c]) begin
                    bmem[c][spill_addr] = spill_data;
                    last_spill_c = c;
                end
                spill_cnt++;
                last_spill_addr = spill_addr;
                last_spill_data = spill_data;
                last_spill_cyc  = cyc;
            end
            if (|fill_req_valid) begin
                fill_cnt++;
                last_fill_cyc = cyc;
                busy = 1;
            end
            if (|rsp_valid) begin
                busy = 0;
                if (exp_c_q.size() == 0) begin
                    chk(0, "R10", "unexpected response", longint'(rsp_valid), 0);
                end else begin
                    int c;
                    logic [DW-1:0] d;
                    int t;
                    c = exp_c_q.pop_front();
                    d = exp_d_q.pop_front();
                    t = exp_t_q.pop_front();
                    last_lat = cyc - t;
                    chk(rsp_valid == (N'(1) << c), "R10", "response routing", longint'(rsp_valid), longint'(N'(1) << c));
                    chk(rsp_data == d, "R2", "response data", longint'(rsp_data), longint'(d));
                end
            end
        end
    end

    // per-client backing stores: fill handler
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (|fill_req_valid)) begin
                int c;
                logic [AW-1:0] a;
                c = 0;
                for (int i = 0; i < N; i++) if (fill_req_valid[i]) c = i;
                a = fill_addr;
                repeat (3) @(posedge clk);
                #1;
                fill_rsp_valid[c] = 1'b1;
                fill_rsp_data[c*DW +: DW] = bmem[c][a];
                @(posedge clk);
                #1;
                fill_rsp_valid = '0;
            end
        end
    end

    task automatic access(int c, bit we, int a, logic [DW-1:0] d);
        @(posedge clk);
        #1;
        req_valid[c] = 1'b1;
        req_we[c]    = we;
        req_addr[c*AW +: AW]  = AW'(a);
        req_wdata[c*DW +: DW] = d;
        forever begin
            @(negedge clk);
            if (req_ready[c]) break;
        end
        if (we) gm[c][a] = d;
        exp_c_q.push_back(c);
        exp_d_q.push_back(gm[c][a]);
        exp_t_q.push_back(cyc);
        acc_order.push_back(c);
        @(posedge clk);
        #1;
        req_valid[c] = 1'b0;
    endtask

    task automatic drain();
        while (exp_c_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic op(int c, bit we, int a, logic [DW-1:0] d);
        access(c, we, a, d);
        drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R8", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int f0, s0;
        for (int c = 0; c < N; c++)
            for (int a = 0; a < 256; a++) begin
                bmem[c][a] = DW'((c << 12) | (a * 7 + 3));
                gm[c][a]   = bmem[c][a];
            end

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == '0 && rsp_valid == '0, "R1", "ready/rsp in reset", longint'({req_ready, rsp_valid}), 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(fill_req_valid == '0 && spill_valid == '0, "R1", "fill/spill idle after reset", longint'({fill_req_valid, spill_valid}), 0);
        chk(req_ready == '0, "R1", "no grant without request", longint'(req_ready), 0);

        // R6: one client fills all ways of set 0 from invalid lines
        f0 = fill_cnt;
        op(0, 0, 'h00, 0); op(0, 0, 'h10, 0); op(0, 0, 'h20, 0); op(0, 0, 'h30, 0);
        chk(fill_cnt == f0 + 4, "R6", "fills for 4 cold misses", fill_cnt - f0, 4);
        chk(spill_cnt == 0, "R5", "no spill for clean/invalid victims", spill_cnt, 0);
        f0 = fill_cnt;
        op(0, 0, 'h00, 0); chk(last_lat == 2, "R3", "hit latency", last_lat, 2);
        op(0, 0, 'h10, 0); op(0, 0, 'h20, 0); op(0, 0, 'h30, 0);
        chk(fill_cnt == f0, "R6", "all 4 ways held by one client hit", fill_cnt - f0, 0);
        chk(last_lat == 2, "R3", "hit latency last", last_lat, 2);

        // R7: LRU victim choice
        f0 = fill_cnt;
        op(1, 0, 'h00, 0);
        chk(fill_cnt == f0 + 1, "R4", "miss on other client same address", fill_cnt - f0, 1);
        chk(spill_cnt == 0, "R5", "clean victim no spill", spill_cnt, 0);
        f0 = fill_cnt;
        op(0, 0, 'h10, 0);
        chk(fill_cnt == f0, "R7", "recent line kept", fill_cnt - f0, 0);
        op(0, 0, 'h00, 0);
        chk(fill_cnt == f0 + 1, "R7", "LRU line was evicted", fill_cnt - f0, 1);
        op(0, 0, 'h20, 0);
        chk(fill_cnt == f0 + 2, "R7", "next LRU evicted", fill_cnt - f0, 2);
        op(1, 0, 'h00, 0);
        chk(fill_cnt == f0 + 2, "R7", "client 1 line survives", fill_cnt - f0, 2);

        // R5: dirty victims spill to owner before fill
        op(2, 1, 'h05, 16'hA000); op(2, 1, 'h15, 16'hA001);
        op(2, 1, 'h25, 16'hA002); op(2, 1, 'h35, 16'hA003);
        chk(spill_cnt == 0, "R6", "invalid ways used before eviction", spill_cnt, 0);
        chk(last_lat > 2, "R4", "write miss waits for fill", last_lat, 3);
        s0 = spill_cnt;
        op(2, 1, 'h45, 16'hA004);
        chk(spill_cnt == s0 + 1, "R5", "dirty victim spilled", spill_cnt - s0, 1);
        chk(last_spill_c == 2, "R5", "spill owner", last_spill_c, 2);
        chk(last_spill_addr == 8'h05, "R5", "spill address", last_spill_addr, 'h05);
        chk(last_spill_data == 16'hA000, "R5", "spill data", last_spill_data, 'hA000);
        chk(last_fill_cyc - last_spill_cyc == 1, "R5", "spill one cycle before fill", last_fill_cyc - last_spill_cyc, 1);
        op(2, 0, 'h05, 0);
        chk(last_spill_addr == 8'h15 && last_spill_data == 16'hA001, "R7", "LRU dirty spill", last_spill_addr, 'h15);

        // R2: same address, different clients
        op(3, 1, 'h77, 16'h1234);
        op(0, 1, 'h77, 16'h4321);
        op(3, 0, 'h77, 0);
        op(0, 0, 'h77, 0);

        // R8/R9: all clients request together while misses are outstanding
        acc_order.delete();
        fork
            access(3, 0, 'h9A, 0);
            access(2, 0, 'h9A, 0);
            access(1, 0, 'h9A, 0);
            access(0, 0, 'h9A, 0);
        join
        drain();
        chk(acc_order.size() == 4, "R9", "all granted", acc_order.size(), 4);
        for (int i = 0; i < 4 && i < acc_order.size(); i++)
            chk(acc_order[i] == i, "R9", "grant order", acc_order[i], i);
        chk(grant_busy == 0, "R8", "grants during miss", grant_busy, 0);

        // mixed traffic
        begin
            int unsigned lcg;
            lcg = 32'h1234_5678;
            for (int k = 0; k < 400; k++) begin
                lcg = lcg * 32'd1103515245 + 32'd12345;
                op(int'(lcg[17:16]), lcg[20], int'(lcg[29:24]), lcg[15:0]);
            end
        end
        chk(grant_busy == 0, "R8", "grants during miss, traffic", grant_busy, 0);
        chk(spill_cnt > 2, "R5", "spills during traffic", spill_cnt, 3);
        chk(exp_c_q.size() == 0, "R10", "all responses delivered", exp_c_q.size(), 0);

        finish_run();
    end
endmodule